// File: doc/BRIEF.md
# 1-Wire ROM Command Layer

This block is the slave-side network layer of a single-wire bus device. After every bus reset it collects an 8-bit function command, one bit per time slot, least significant bit first, from a bit-level slot engine. It then serves that command. It can send out its 64-bit identity, compare the master's 64 bits against that identity, skip addressing altogether, or take part in the bit-wise search arbitration. When the command completes in its favour, it raises a level grant that opens the memory command layer above it. When it is deselected, it releases the line until the next bus reset.

The slot engine talks to it through a plain strobe handshake. The block always presents `slot_tx`, the level it wants on the line for the coming slot, where 1 means leave the line released. The engine raises `slot_stb` for one clock when a slot ends and supplies the sampled line level on `slot_rx` in that same cycle. There is no back-pressure: every strobe is taken. `slot_tx` for the next slot is valid from the clock after the strobe. `bus_reset` is a one-clock pulse from the slot engine.

The identity is built from two parameters, a family byte and a 48-bit serial number, plus a CRC byte computed at elaboration.

Top module: `owr_rom_layer`

## Requirements
- R1: After `rst_n` or a `bus_reset` pulse, `slot_tx` is 1 and `mem_grant` is 0. The next 8 strobes form the command byte, the first strobe giving bit 0. `slot_tx` stays 1 during these 8 slots.
- R2: With command 33h, the next 64 slots present identity bits 0..63 in order on `slot_tx`. `mem_grant` is 1 in the cycle after the 64th strobe.
- R3: With command 55h, `slot_rx` of the next 64 strobes is compared with identity bits 0..63 in order, and `slot_tx` stays 1. If all 64 agree, `mem_grant` is 1 after the 64th strobe.
- R4: During 55h, any disagreeing bit deselects the block. From then on, `slot_tx` stays 1 and `mem_grant` stays 0 for all further strobes until a `bus_reset`.
- R5: With command CCh, `mem_grant` is 1 in the cycle after the 8th command strobe, with no identity slots.
- R6: With command F0h, each identity bit i takes three slots. In the first, `slot_tx` is bit i. In the second, it is the inverse of bit i. In the third, it is 1 and `slot_rx` is taken as the master's chosen bit. If all 64 chosen bits equal the identity, `mem_grant` is 1 after the 192nd strobe.
- R7: During F0h, a chosen bit that differs from the identity bit deselects the block until `bus_reset`, with the same silence as R4.
- R8: Any command byte other than 33h, 55h, CCh or F0h deselects the block until `bus_reset`, with the same silence as R4.
- R9: A `bus_reset` returns the block to command collection from any state, including partway through a command or identity transfer. A `bus_reset` wins over a strobe in the same cycle.
- R10: Identity bits [7:0] are the family parameter, bits [55:8] are the serial parameter, and bits [63:56] are a CRC of bits [55:0]. The CRC uses x^8+x^5+x^4+1, starts from zero and takes bits LSB first, so running all 64 bits through the same CRC leaves zero.
- R11: While `mem_grant` is 1, strobes have no effect: `mem_grant` stays 1 and `slot_tx` stays 1 until `bus_reset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-clock pulse: a bus reset and presence pulse occurred |
| slot_stb | input | 1 | One-clock pulse at the end of each time slot |
| slot_rx | input | 1 | Line level sampled in the slot closed by `slot_stb` |
| slot_tx | output | 1 | Level wanted for the next slot; 1 releases the line |
| mem_grant | output | 1 | Memory command layer may take over |

## Verification
Every command is run from a table of vectors.

- Read shows the bit order of the identity.
- Match is run three ways: with a perfect copy, with the first bit flipped and with the last bit flipped. These separate an early exit from a late one, and a late exit from a grant.
- Search is run with no conflict, with a conflict in the middle and with a conflict on the final bit. This shows that the inverted slot follows the true slot and that the block goes silent right after the conflicting bit.
- An undefined command, a reset in mid-transfer and a reset coincident with a command strobe show that reset always restarts command collection.
- The identity read from the port is checked for a zero CRC residue.

// File: rtl/owr_pkg.sv
package owr_pkg;
  localparam int CMD_W = 8;
  localparam int FAM_W = 8;
  localparam int SER_W = 48;
  localparam int CRC_W = 8;
  localparam int ID_W  = FAM_W + SER_W + CRC_W;
  localparam int PHASES = 3;

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;

  typedef enum logic [2:0] {
    ST_CMD, ST_READ, ST_MATCH, ST_SEARCH, ST_GRANT, ST_MUTE
  } rom_state_t;

  // Reflected CRC, polynomial x^8+x^5+x^4+1, bits taken LSB first
  function automatic logic [CRC_W-1:0] id_crc(input logic [FAM_W+SER_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = 0; i < FAM_W + SER_W; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction
endpackage

// File: rtl/owr_cmd_rx.sv
module owr_cmd_rx
  import owr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             rx,
  output logic             cmd_valid,
  output logic [CMD_W-1:0] cmd_byte
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-2:0] hold;
  logic [CNT_W-1:0] cnt;

  assign cmd_byte  = {rx, hold};
  assign cmd_valid = en && (cnt == CNT_W'(CMD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      cnt  <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (en) begin
      hold <= cmd_byte[CMD_W-1:1];
      cnt  <= cmd_valid ? '0 : cnt + 1'b1;
    end
  end

  // R1: a completed command byte restarts the bit count
  assert_cmd_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (cnt == '0));
endmodule

// File: rtl/owr_slot_seq.sv
module owr_slot_seq
  import owr_pkg::*;
#(
  parameter int NBITS = ID_W,
  parameter int NPH   = PHASES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step_bit,
  input  logic                     step_phase,
  output logic [$clog2(NBITS)-1:0] idx,
  output logic [$clog2(NPH)-1:0]   phase,
  output logic                     last_bit,
  output logic                     last_phase
);
  localparam int IDX_W = $clog2(NBITS);
  localparam int PH_W  = $clog2(NPH);

  assign last_bit   = (idx == IDX_W'(NBITS - 1));
  assign last_phase = (phase == PH_W'(NPH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= '0;
    end else if (clr) begin
      idx   <= '0;
      phase <= '0;
    end else if (step_bit) begin
      idx   <= idx + 1'b1;
      phase <= '0;
    end else if (step_phase) begin
      phase <= phase + 1'b1;
    end
  end

  // R6: phase never passes the last slot of a bit
  assert_phase_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_phase && !clr && !step_bit) |=> !$changed(phase) || phase == '0);
endmodule

// File: rtl/owr_rom_layer.sv
module owr_rom_layer
  import owr_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY_CODE = 8'h09,
  parameter logic [SER_W-1:0] SERIAL_NUM  = 48'h0000_1A2B_3C4D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic slot_stb,
  input  logic slot_rx,
  output logic slot_tx,
  output logic mem_grant
);
  localparam int IDX_W = $clog2(ID_W);
  localparam int PH_W  = $clog2(PHASES);
  localparam logic [CRC_W-1:0] ID_CRC = id_crc({SERIAL_NUM, FAMILY_CODE});
  localparam logic [ID_W-1:0]  IDENT  = {ID_CRC, SERIAL_NUM, FAMILY_CODE};

  rom_state_t       st, st_n;
  logic             cmd_en, cmd_valid;
  logic [CMD_W-1:0] cmd_byte;
  logic             seq_clr, seq_bit, seq_ph;
  logic [IDX_W-1:0] idx;
  logic [PH_W-1:0]  phase;
  logic             last_bit, last_phase;
  logic             id_bit;

  assign cmd_en = slot_stb && !bus_reset && (st == ST_CMD);

  owr_cmd_rx u_cmd (
    .clk(clk), .rst_n(rst_n), .clr(bus_reset), .en(cmd_en), .rx(slot_rx),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
  );

  owr_slot_seq #(.NBITS(ID_W), .NPH(PHASES)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .step_bit(seq_bit),
    .step_phase(seq_ph), .idx(idx), .phase(phase),
    .last_bit(last_bit), .last_phase(last_phase)
  );

  assign id_bit = IDENT[idx];

  always_comb begin
    st_n    = st;
    seq_clr = 1'b0;
    seq_bit = 1'b0;
    seq_ph  = 1'b0;
    if (bus_reset) begin
      st_n    = ST_CMD;
      seq_clr = 1'b1;
    end else if (slot_stb) begin
      unique case (st)
        ST_CMD: if (cmd_valid) begin
          seq_clr = 1'b1;
          case (cmd_byte)
            CMD_READ:   st_n = ST_READ;
            CMD_MATCH:  st_n = ST_MATCH;
            CMD_SKIP:   st_n = ST_GRANT;
            CMD_SEARCH: st_n = ST_SEARCH;
            default:    st_n = ST_MUTE;
          endcase
        end
        ST_READ: begin
          if (last_bit) st_n = ST_GRANT;
          else          seq_bit = 1'b1;
        end
        ST_MATCH: begin
          if (slot_rx != id_bit) st_n = ST_MUTE;
          else if (last_bit)     st_n = ST_GRANT;
          else                   seq_bit = 1'b1;
        end
        ST_SEARCH: begin
          if (!last_phase)            seq_ph = 1'b1;
          else if (slot_rx != id_bit) st_n = ST_MUTE;
          else if (last_bit)          st_n = ST_GRANT;
          else                        seq_bit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_CMD;
    else        st <= st_n;
  end

  always_comb begin
    unique case (st)
      ST_READ:   slot_tx = id_bit;
      ST_SEARCH: slot_tx = (phase == '0) ? id_bit : (phase == PH_W'(1)) ? ~id_bit : 1'b1;
      default:   slot_tx = 1'b1;
    endcase
  end

  assign mem_grant = (st == ST_GRANT);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (!mem_grant && slot_tx));

  assert_grant_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_grant && !bus_reset) |=> (mem_grant && slot_tx));

  assert_grant_on_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_grant) |-> $past(slot_stb));

  assert_inverse_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SEARCH && phase == PH_W'(1) && $past(st) == ST_SEARCH && $past(phase) == '0)
      |-> (slot_tx != $past(slot_tx)));

  assert_mute_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MUTE && !bus_reset) |=> (st == ST_MUTE && slot_tx && !mem_grant));
endmodule

// File: tb/owr_rom_layer_bench.sv
`timescale 1ns/1ps
module owr_rom_layer_bench;
  localparam logic [7:0]  FAM = 8'h09;
  localparam logic [47:0] SER = 48'h0000_1A2B_3C4D;
  localparam int NV = 9;
  // {command, flip position (64 = none), expected grant}
  localparam logic [23:0] VECS [0:NV-1] = '{
    {8'h33, 8'd64, 8'd1},
    {8'h55, 8'd64, 8'd1},
    {8'h55, 8'd0,  8'd0},
    {8'h55, 8'd63, 8'd0},
    {8'hCC, 8'd64, 8'd1},
    {8'hF0, 8'd64, 8'd1},
    {8'hF0, 8'd17, 8'd0},
    {8'hF0, 8'd63, 8'd0},
    {8'h3C, 8'd64, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, slot_stb = 1'b0, slot_rx = 1'b1;
  logic slot_tx, mem_grant;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [63:0] exp_id;

  always #2 clk = ~clk;

  owr_rom_layer #(.FAMILY_CODE(FAM), .SERIAL_NUM(SER)) u_owr_rom_layer (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_stb(slot_stb),
    .slot_rx(slot_rx), .slot_tx(slot_tx), .mem_grant(mem_grant)
  );

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return {fb, c[7], c[6], c[5], c[4] ^ fb, c[3] ^ fb, c[2], c[1]};
  endfunction

  function automatic logic [7:0] crc_run(input logic [63:0] d, input int n);
    logic [7:0] c = '0;
    for (int i = 0; i < n; i++) c = crc_step(c, d[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic rx, output logic tx);
    @(negedge clk);
    tx = slot_tx;
    slot_rx = rx;
    slot_stb = 1'b1;
    @(negedge clk);
    slot_stb = 1'b0;
    slot_rx = 1'b1;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic send_cmd(input logic [7:0] c, output int quiet_bad);
    logic t;
    quiet_bad = 0;
    for (int i = 0; i < 8; i++) begin
      slot(c[i], t);
      if (t !== 1'b1) quiet_bad++;
    end
  endtask

  task automatic read_id(output logic [63:0] got);
    logic t;
    for (int i = 0; i < 64; i++) begin
      slot(1'b1, t);
      got[i] = t;
    end
  endtask

  task automatic run_vec(input logic [7:0] cmd, input int flip, input logic eg);
    int qb, bad;
    logic t, a, b, c;
    logic [63:0] got;
    pulse_reset();
    send_cmd(cmd, qb);
    chk(qb == 0, "R1 line released during command", 64'(qb), 64'd0);
    bad = 0;
    case (cmd)
      8'h33: begin
        read_id(got);
        chk(got == exp_id, "R2 identity order", got, exp_id);
      end
      8'h55: begin
        for (int i = 0; i < 64; i++) begin
          slot(exp_id[i] ^ (i == flip), t);
          if (t !== 1'b1) bad++;
        end
        chk(bad == 0, flip < 64 ? "R4 silent after mismatch" : "R3 released during match", 64'(bad), 64'd0);
      end
      8'hCC: ;
      8'hF0: begin
        for (int i = 0; i < 64; i++) begin
          slot(1'b1, a);
          slot(1'b1, b);
          slot((i == flip) ? ~exp_id[i] : exp_id[i], c);
          if (i <= flip) begin
            if (a !== exp_id[i] || b !== ~exp_id[i]) bad++;
          end else if (a !== 1'b1 || b !== 1'b1) bad++;
          if (c !== 1'b1) bad++;
        end
        chk(bad == 0, flip < 64 ? "R7 search drop-out" : "R6 search bit and inverse", 64'(bad), 64'd0);
      end
      default: begin
        for (int i = 0; i < 64; i++) begin
          slot(1'b0, t);
          if (t !== 1'b1 || mem_grant !== 1'b0) bad++;
        end
        chk(bad == 0, "R8 unknown command silent", 64'(bad), 64'd0);
      end
    endcase
    chk(mem_grant === eg,
        cmd == 8'hCC ? "R5 skip grant" : cmd == 8'h33 ? "R2 grant" :
        cmd == 8'h55 ? (flip < 64 ? "R4 no grant" : "R3 grant") :
        cmd == 8'hF0 ? (flip < 64 ? "R7 no grant" : "R6 grant") : "R8 no grant",
        64'(mem_grant), 64'(eg));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int qb, bad;
    logic t;
    logic [63:0] got;
    exp_id = {8'h00, SER, FAM};
    exp_id[63:56] = crc_run(exp_id, 56);
    repeat (3) @(negedge clk);
    chk(slot_tx === 1'b1 && mem_grant === 1'b0, "R1 reset state", {slot_tx, mem_grant}, 64'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_tx === 1'b1 && mem_grant === 1'b0, "R1 idle after reset", {slot_tx, mem_grant}, 64'b10);

    for (int v = 0; v < NV; v++)
      run_vec(VECS[v][23:16], int'(VECS[v][15:8]), VECS[v][0]);

    // R10 identity layout and CRC residue, read through the port
    pulse_reset();
    send_cmd(8'h33, qb);
    read_id(got);
    chk(crc_run(got, 64) == 8'h00, "R10 CRC residue", 64'(crc_run(got, 64)), 64'd0);
    chk(got[7:0] == FAM && got[55:8] == SER, "R10 family and serial fields", got[55:0], {SER, FAM});

    // R11 strobes ignored while granted
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      slot(i[0], t);
      if (t !== 1'b1 || mem_grant !== 1'b1) bad++;
    end
    chk(bad == 0, "R11 grant holds", 64'(bad), 64'd0);

    // R9 reset while granted, then reset partway through a read
    pulse_reset();
    chk(mem_grant === 1'b0 && slot_tx === 1'b1, "R9 reset clears grant", 64'(mem_grant), 64'd0);
    send_cmd(8'h33, qb);
    for (int i = 0; i < 10; i++) slot(1'b1, t);
    pulse_reset();
    send_cmd(8'h33, qb);
    read_id(got);
    chk(got == exp_id, "R9 read restarts at bit 0", got, exp_id);

    // R9 reset partway through a command byte, coinciding with the 8th strobe
    pulse_reset();
    for (int i = 0; i < 7; i++) slot(8'hCC >> i, t);
    @(negedge clk);
    bus_reset = 1'b1;
    slot_stb = 1'b1;
    slot_rx = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
    slot_stb = 1'b0;
    chk(mem_grant === 1'b0, "R9 reset beats strobe", 64'(mem_grant), 64'd0);
    send_cmd(8'hCC, qb);
    chk(mem_grant === 1'b1, "R9 command count restarted", 64'(mem_grant), 64'd1);

    // R4 reset leaves deselection
    pulse_reset();
    send_cmd(8'h55, qb);
    slot(~exp_id[0], t);
    pulse_reset();
    send_cmd(8'hCC, qb);
    chk(mem_grant === 1'b1, "R4 reset ends deselection", 64'(mem_grant), 64'd1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule